// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block records the value of an external free-running counter at the moment a chosen transition appears on an asynchronous input pin. The pin first passes through a synchroniser. It can then optionally pass through a digital agreement filter that rejects pulses shorter than the filter length. A transition detector then fires on either the rising or the falling level change, depending on a select input. On each firing, the counter value is stored in a capture register and a sticky event flag is raised. The flag combines with an enable to form an interrupt request.

Software reads the capture register to timestamp external events, and clears the flag with a one-cycle strobe. When the capture register is being used elsewhere as the counter's wrap limit, a mode input blocks all captures so that the limit value is never overwritten.

Top module: `icap_unit`

## Requirements
- R1: With the filter off, a pin change applied before clock edge E1 loads the capture register at edge E3 with the counter value presented during the cycle before E3.
- R2: Edge select 1 captures only on a 0-to-1 pin change, and edge select 0 captures only on a 1-to-0 change. The opposite transition captures nothing.
- R3: With the filter on, the same pin change is captured four edges later (at E7), with the counter value present before E7.
- R4: With the filter on, a pin pulse lasting three clock cycles produces no capture, and a pulse lasting four cycles produces one.
- R5: A capture sets the flag. The flag stays set with no further stimulus and is cleared by a one-cycle clear strobe.
- R6: When a capture and a clear strobe fall on the same edge, the flag remains set and the capture register takes the new value.
- R7: The interrupt output is high exactly when the flag is set and the interrupt enable is 1.
- R8: While the top-mode input is 1, pin transitions neither change the capture register nor set the flag. Returning top-mode to 0 with the pin steady produces no capture.
- R9: Reset clears the capture register, flag and interrupt. A pin held at 1 through reset yields no capture after reset is released.
- R10: Toggling the edge select while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W (16) | Free-running counter value |
| filt_en_i | input | 1 | 1 = agreement filter in path |
| edge_sel_i | input | 1 | 1 = rising, 0 = falling |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| top_mode_i | input | 1 | 1 = capture register used as wrap limit; capture blocked |
| cap_o | output | CNT_W (16) | Capture register |
| flag_o | output | 1 | Capture event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear strobe that arrives on exactly the edge where a capture lands. That edge sits several registers behind the pin. The bench records the counter at the pin change and counts edges through the synchroniser and detector, so the strobe is raised for precisely the third edge. The glitch-rejection boundary is reached the same way, with pulses held for exactly three and exactly four cycles.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        if (rst_i) begin
            st_d.chain = {STAGES{d_i}};
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int TAPS = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic s_i,
    output logic out_o
);

    localparam int HW = TAPS - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          out;
    } filt_st_t;

    filt_st_t         st_d, st_q;
    logic [TAPS-1:0]  window;
    logic             agree;

    assign window = {st_q.hist, s_i};
    assign agree  = (&window) | ~(|window);

    always_comb begin
        st_d = st_q;
        st_d.hist[0] = s_i;
        for (int i = 1; i < HW; i++) begin
            st_d.hist[i] = st_q.hist[i-1];
        end
        if (agree) begin
            st_d.out = s_i;
        end
        if (rst_i) begin
            st_d.hist = {HW{s_i}};
            st_d.out  = s_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R4: the filtered level only ever moves to the sample seen one edge before
    a_r4_filter_follows_sample: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.out) |-> (st_q.out == $past(s_i)));

endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    input  logic sel_i,
    input  logic arm_i,
    output logic fire_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t  st_d, st_q;
    edge_sel_e sel;
    logic      rise, fall;

    assign sel  = edge_sel_e'(sel_i);
    assign rise = lvl_i & ~st_q.prev;
    assign fall = ~lvl_i & st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign fire_o = arm_i & ((sel == EDGE_RISE) ? rise : fall);

    // R10: a trigger needs the level itself to have moved since last edge
    a_r10_fire_needs_change: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |-> (lvl_i != st_q.prev));

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             filt_en_i,
    input  logic             edge_sel_i,
    input  logic             flag_clr_i,
    input  logic             irq_en_i,
    input  logic             top_mode_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     sync_lvl;
    logic     filt_lvl;
    logic     det_lvl;
    logic     fire;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    generate
        if (FILT_TAPS > 1) begin : g_filt
            icap_filter #(.TAPS(FILT_TAPS)) u_filt (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .s_i   (sync_lvl),
                .out_o (filt_lvl)
            );
        end else begin : g_nofilt
            assign filt_lvl = sync_lvl;
        end
    endgenerate

    assign det_lvl = filt_en_i ? filt_lvl : sync_lvl;

    icap_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (det_lvl),
        .sel_i  (edge_sel_i),
        .arm_i  (~top_mode_i),
        .fire_o (fire)
    );

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.cap = count_i;
        end
        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        if (fire) begin
            st_d.flag = 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & irq_en_i;

    // R1: a trigger stores the counter value seen on that edge
    a_r1_capture_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |=> (st_q.cap == $past(count_i)) && st_q.flag);

    // R5: without a clear the flag is sticky
    a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.flag && !flag_clr_i) |=> st_q.flag);

    // R5: a clear with no trigger drops the flag
    a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_clr_i && !fire) |=> !st_q.flag);

    // R6: simultaneous trigger and clear leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_clr_i && fire) |=> st_q.flag);

    // R8: capture register frozen while it serves as the wrap limit
    a_r8_top_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        top_mode_i |=> $stable(st_q.cap));

    // R7: interrupt only with enable
    a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (irq_en_i && flag_o));

endmodule

// File: tb/icap_unit_bench.sv
module icap_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 8;

    // vector bits: [7]=filter en, [6]=edge sel, [5]=pin level, [4]=expect capture, [3:0]=offset
    localparam logic [7:0] VECS [0:NVEC-1] = '{
        8'b0_1_1_1_0010,   // R1 R2 rising captured
        8'b0_1_0_0_0010,   // R2 falling ignored with sel 1
        8'b0_0_1_0_0010,   // R2 rising ignored with sel 0
        8'b0_0_0_1_0010,   // R2 falling captured
        8'b1_1_1_1_0110,   // R3 filtered rising
        8'b1_0_0_1_0110,   // R3 filtered falling
        8'b1_1_1_1_0110,   // R3 filtered rising again
        8'b0_0_0_1_0010    // R1 unfiltered falling
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pin = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic             fen = 1'b0;
    logic             sel = 1'b1;
    logic             clr = 1'b0;
    logic             ie  = 1'b0;
    logic             top = 1'b0;
    logic [CNT_W-1:0] cap;
    logic             flag;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;

    icap_unit u_icap_unit (
        .clk_i      (clk),
        .rst_i      (rst),
        .pin_i      (pin),
        .count_i    (cnt),
        .filt_en_i  (fen),
        .edge_sel_i (sel),
        .flag_clr_i (clr),
        .irq_en_i   (ie),
        .top_mode_i (top),
        .cap_o      (cap),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] held;

        // R9: reset state, pin low
        cyc(4);
        chk("R9 cap reset", cap, 0);
        chk("R9 flag reset", flag, 0);
        chk("R9 irq reset", irq, 0);
        rst = 1'b0;
        cyc(6);

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] off;
            fen = VECS[v][7];
            sel = VECS[v][6];
            pin = VECS[v][5];
            off = VECS[v][3:0];
            c   = cnt;
            cyc(off);
            chk("R1/R3 no early capture", flag, 0);
            cyc(1);
            chk(VECS[v][7] ? "R3 flag" : "R2 flag", flag, VECS[v][4]);
            if (VECS[v][4]) chk(VECS[v][7] ? "R3 value" : "R1 value", cap, c + off);
            pulse_clear();
            cyc(8);
        end
        // pin is now 0, filter disabled

        // R5: flag sticky then cleared by the strobe
        sel = 1'b1;
        pin = 1'b1;
        c   = cnt;
        cyc(3);
        chk("R5 set", flag, 1);
        chk("R1 value rising", cap, c + 2);
        cyc(20);
        chk("R5 sticky", flag, 1);

        // R7: interrupt gating
        chk("R7 irq off while disabled", irq, 0);
        ie = 1'b1;
        cyc(1);
        chk("R7 irq on", irq, 1);

        // R6: clear coincides with a capture
        sel = 1'b0;
        pin = 1'b0;
        c   = cnt;
        cyc(2);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        chk("R6 flag kept", flag, 1);
        chk("R6 value new", cap, c + 2);
        pulse_clear();
        chk("R5 cleared", flag, 0);
        chk("R7 irq follows flag", irq, 0);
        cyc(4);

        // R4: three-cycle glitch rejected, four-cycle pulse accepted
        fen = 1'b1;
        sel = 1'b1;
        cyc(4);
        pin = 1'b1;
        cyc(3);
        pin = 1'b0;
        cyc(14);
        chk("R4 short pulse rejected", flag, 0);
        pin = 1'b1;
        c   = cnt;
        cyc(4);
        pin = 1'b0;
        cyc(3);
        chk("R4 long pulse accepted", flag, 1);
        chk("R4 value", cap, c + 6);
        cyc(10);
        pulse_clear();
        fen = 1'b0;
        cyc(4);

        // R10: edge select toggles with steady pin
        pin = 1'b1;
        sel = 1'b0;
        cyc(6);
        for (int k = 0; k < 6; k++) begin
            sel = ~sel;
            cyc(2);
        end
        cyc(4);
        chk("R10 no capture on select change", flag, 0);

        // R8: blocked while in top mode
        held = cap;
        top  = 1'b1;
        sel  = 1'b0;
        pin  = 1'b0;
        cyc(8);
        sel  = 1'b1;
        pin  = 1'b1;
        cyc(8);
        chk("R8 flag blocked", flag, 0);
        chk("R8 cap held", cap, held);
        top = 1'b0;
        cyc(8);
        chk("R8 no capture on release", flag, 0);
        chk("R8 cap still held", cap, held);

        // R9: pin high through reset
        rst = 1'b1;
        pin = 1'b1;
        sel = 1'b1;
        cyc(4);
        rst = 1'b0;
        cyc(10);
        chk("R9 no capture after reset", flag, 0);
        chk("R9 cap zero", cap, 0);

        finish_run();
    end

endmodule